// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block enforces in-band software flow control for a serial port. It sits between a UART receiver, a UART transmitter and a receive FIFO. Each received character is compared with two programmable codes. A stop code halts the local transmitter once the character it is currently shifting has finished. A go code lets it run again. Both codes are consumed here and never reach the FIFO. All other characters pass straight through to the FIFO write port in the same cycle.

In the other direction the block watches the FIFO occupancy. When the occupancy reaches a programmable threshold, it raises a request to send the stop code to the far end. When the occupancy drops back below the threshold, it requests the go code. A pending request holds back normal data and is still served while the local transmitter is paused. Four configuration registers set the enable, the two codes and the threshold. They are loaded through a simple write strobe.

Top module: `sw_flow_ctrl`

## Requirements
- R1: After reset txPause and sendReq are low, flow control is disabled, the go code is 8'h11, the stop code is 8'h13 and the threshold is 450.
- R2: With flow control enabled and txBusy low, a received character equal to the stop code raises txPause on the clock edge that accepts it.
- R3: A stop code received while txBusy is high leaves txPause low until the first clock edge at which txBusy is low, and txPause rises on that edge.
- R4: A received go code clears txPause on the next edge and cancels a stop that is still waiting for txBusy to fall.
- R5: While enabled, received characters equal to either code are not written to the FIFO. Every other received character appears on fifoWrEn/fifoWrData in the same cycle as rxValid.
- R6: When fifoLevel is at or above the threshold, sendReq rises with sendChar equal to the stop code. Both stay unchanged until sendAck is sampled high.
- R7: After a stop code has been sent, fifoLevel below the threshold raises a sendReq carrying the go code.
- R8: Only one request is made per threshold crossing. A level that stays on the same side after sendAck produces no further request.
- R9: txDataGrant follows txDataReq only when txPause is low and no request is pending. sendReq is still raised while txPause is high.
- R10: While flow control is disabled, txPause and sendReq go low on the next edge, any pending request is dropped, and every received character is forwarded to the FIFO.
- R11: A write with cfgWe high stores cfgWdata: address 0 bit 0 is the enable, address 1 the go code, address 2 the stop code, address 3 the threshold. New values take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgWdata | input | CNT_W | Configuration write data |
| rxValid | input | 1 | Received character strobe |
| rxData | input | DATA_W | Received character |
| fifoWrEn | output | 1 | Write strobe to the receive FIFO |
| fifoWrData | output | DATA_W | Data to the receive FIFO |
| fifoLevel | input | CNT_W | Receive FIFO occupancy |
| txBusy | input | 1 | Transmitter is shifting a character |
| txDataReq | input | 1 | Transmitter wants to start a data character |
| txDataGrant | output | 1 | Data character may start |
| txPause | output | 1 | Local transmitter halted by the far end |
| sendReq | output | 1 | Request to send a flow-control character |
| sendChar | output | DATA_W | Flow-control character to send |
| sendAck | input | 1 | Transmitter accepted sendChar |

## Verification
The bench sends a stop code while txBusy is high and checks that txPause stays low until the busy phase ends. A design that paused at once would cut a character in half. It sends stop then go inside one busy phase, because a design that forgot the armed stop would pause after go. It steps the level between 449 and 450 to check the default boundary, and holds the level after each acknowledge. A design with an off-by-one compare, or one that repeated its request, would send wrong or extra characters that the send scoreboard rejects. It also disables flow control while paused with a request outstanding. A design that kept that state would leave the transmitter stuck or send a stale character.

// File: rtl/sw_flow_pkg.sv
package sw_flow_pkg;

  // Decoded view of the datapath handed to control
  typedef struct packed {
    logic enable;
    logic xoffHit;
    logic xonHit;
    logic atOrAbove;
  } dp_status_t;

  // Strobes from control into the datapath
  typedef struct packed {
    logic loadXoff;
    logic loadXon;
  } ctl_strobe_t;

  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_XON    = 2'd1;
  localparam logic [1:0] ADDR_XOFF   = 2'd2;
  localparam logic [1:0] ADDR_THRESH = 2'd3;

endpackage

// File: rtl/sw_flow_dp.sv
module sw_flow_dp
  import sw_flow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 10,
  parameter int DEF_THRESH = 450,
  parameter logic [DATA_W-1:0] DEF_XON = 8'h11,
  parameter logic [DATA_W-1:0] DEF_XOFF = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CNT_W-1:0]  cfgWdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [CNT_W-1:0]  fifoLevel,
  input  ctl_strobe_t       strobe,
  output dp_status_t        status,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic [DATA_W-1:0] sendChar
);

  localparam int NUM_CODES = 2;
  localparam int XON_IDX = 0;
  localparam int XOFF_IDX = 1;
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(DEF_THRESH);

  logic              enReg;
  logic [DATA_W-1:0] xonReg;
  logic [DATA_W-1:0] xoffReg;
  logic [CNT_W-1:0]  thrReg;
  logic [DATA_W-1:0] charReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      xonReg  <= DEF_XON;
      xoffReg <= DEF_XOFF;
      thrReg  <= THR_RST;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_ENABLE: enReg   <= cfgWdata[0];
        ADDR_XON:    xonReg  <= cfgWdata[DATA_W-1:0];
        ADDR_XOFF:   xoffReg <= cfgWdata[DATA_W-1:0];
        default:     thrReg  <= cfgWdata;
      endcase
    end
  end

  // One comparator per programmable code
  logic [DATA_W-1:0]    codeSel [NUM_CODES];
  logic [NUM_CODES-1:0] matchVec;

  assign codeSel[XON_IDX]  = xonReg;
  assign codeSel[XOFF_IDX] = xoffReg;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
    assign matchVec[g] = (rxData == codeSel[g]);
  end

  assign status.enable    = enReg;
  assign status.xoffHit   = enReg & rxValid & matchVec[XOFF_IDX];
  assign status.xonHit    = enReg & rxValid & matchVec[XON_IDX] & ~matchVec[XOFF_IDX];
  assign status.atOrAbove = (fifoLevel >= thrReg);

  // Codes are consumed; everything else goes to the FIFO
  assign fifoWrEn   = rxValid & ~(enReg & (|matchVec));
  assign fifoWrData = rxData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charReg <= '0;
    end else if (strobe.loadXoff) begin
      charReg <= xoffReg;
    end else if (strobe.loadXon) begin
      charReg <= xonReg;
    end
  end

  assign sendChar = charReg;

endmodule

// File: rtl/sw_flow_ctl.sv
module sw_flow_ctl
  import sw_flow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dp_status_t  status,
  input  logic        txBusy,
  input  logic        sendAck,
  output ctl_strobe_t strobe,
  output logic        paused,
  output logic        pending
);

  logic stopArmed;
  logic lastWasXoff;
  logic queueXoff;
  logic queueXon;

  assign queueXoff = status.enable & ~pending & status.atOrAbove & ~lastWasXoff;
  assign queueXon  = status.enable & ~pending & ~status.atOrAbove & lastWasXoff;

  assign strobe.loadXoff = queueXoff;
  assign strobe.loadXon  = queueXon;

  always_ff @(posedge clk) begin
    if (!rstN || !status.enable) begin
      paused      <= 1'b0;
      stopArmed   <= 1'b0;
      pending     <= 1'b0;
      lastWasXoff <= 1'b0;
    end else begin
      // Receive side: stop waits for the character in flight
      if (status.xoffHit) begin
        if (txBusy) stopArmed <= 1'b1;
        else        paused    <= 1'b1;
      end else if (status.xonHit) begin
        paused    <= 1'b0;
        stopArmed <= 1'b0;
      end else if (stopArmed && !txBusy) begin
        paused    <= 1'b1;
        stopArmed <= 1'b0;
      end

      // Transmit side: one request per threshold crossing
      if (pending) begin
        if (sendAck) pending <= 1'b0;
      end else if (queueXoff) begin
        pending     <= 1'b1;
        lastWasXoff <= 1'b1;
      end else if (queueXon) begin
        pending     <= 1'b1;
        lastWasXoff <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sw_flow_ctrl.sv
module sw_flow_ctrl
  import sw_flow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 10,
  parameter int DEF_THRESH = 450
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CNT_W-1:0]  cfgWdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  input  logic [CNT_W-1:0]  fifoLevel,
  input  logic              txBusy,
  input  logic              txDataReq,
  output logic              txDataGrant,
  output logic              txPause,
  output logic              sendReq,
  output logic [DATA_W-1:0] sendChar,
  input  logic              sendAck
);

  dp_status_t  dpStatus;
  ctl_strobe_t ctlStrobe;
  logic        pausedQ;
  logic        pendingQ;

  sw_flow_dp #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_THRESH(DEF_THRESH)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rxValid(rxValid), .rxData(rxData), .fifoLevel(fifoLevel),
    .strobe(ctlStrobe), .status(dpStatus),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .sendChar(sendChar)
  );

  sw_flow_ctl u_ctl (
    .clk(clk), .rstN(rstN), .status(dpStatus),
    .txBusy(txBusy), .sendAck(sendAck),
    .strobe(ctlStrobe), .paused(pausedQ), .pending(pendingQ)
  );

  assign txPause     = pausedQ;
  assign sendReq     = pendingQ;
  assign txDataGrant = txDataReq & ~pausedQ & ~pendingQ;

endmodule

// File: rtl/sw_flow_ctrl_chk.sv
module sw_flow_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              xonHit,
  input logic              xoffHit,
  input logic              txBusy,
  input logic              txPause,
  input logic              sendReq,
  input logic              sendAck,
  input logic [DATA_W-1:0] sendChar,
  input logic              fifoWrEn
);

  // R6
  send_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && !sendAck) |=> ((sendReq && $stable(sendChar)) || !enable));

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!txPause && !sendReq));

  // R5
  consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xonHit || xoffHit) |-> !fifoWrEn);

  // R4
  resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    xonHit |=> !txPause);

  // R3
  pause_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPause) |-> !$past(txBusy));

endmodule

bind sw_flow_ctrl sw_flow_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .enable(dpStatus.enable), .xonHit(dpStatus.xonHit), .xoffHit(dpStatus.xoffHit),
  .txBusy(txBusy), .txPause(txPause), .sendReq(sendReq), .sendAck(sendAck),
  .sendChar(sendChar), .fifoWrEn(fifoWrEn)
);

// File: tb/sw_flow_ctrl_bench.sv
module sw_flow_ctrl_bench;

  localparam int PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int CNT_W = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [1:0]        cfgAddr = '0;
  logic [CNT_W-1:0]  cfgWdata = '0;
  logic              rxValid = 1'b0;
  logic [DATA_W-1:0] rxData = '0;
  logic              fifoWrEn;
  logic [DATA_W-1:0] fifoWrData;
  logic [CNT_W-1:0]  fifoLevel = '0;
  logic              txBusy = 1'b0;
  logic              txDataReq = 1'b0;
  logic              txDataGrant;
  logic              txPause;
  logic              sendReq;
  logic [DATA_W-1:0] sendChar;
  logic              sendAck = 1'b0;

  int  tests = 0;
  int  fails = 0;
  bit  autoAck = 1'b1;
  bit  finished = 1'b0;
  logic [DATA_W-1:0] fifoQ [$];
  logic [DATA_W-1:0] sendQ [$];

  always #(PERIOD/2) clk = ~clk;

  sw_flow_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sw_flow_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rxValid(rxValid), .rxData(rxData), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoLevel(fifoLevel), .txBusy(txBusy), .txDataReq(txDataReq),
    .txDataGrant(txDataGrant), .txPause(txPause), .sendReq(sendReq),
    .sendChar(sendChar), .sendAck(sendAck)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] a, input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = CNT_W'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Driver: pushes the expected FIFO write when the character should pass
  task automatic sendRx(input logic [DATA_W-1:0] d, input bit expectFwd);
    @(negedge clk);
    rxValid = 1'b1; rxData = d;
    if (expectFwd) fifoQ.push_back(d);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic setLevel(input int lvl, input bit expectSend, input logic [DATA_W-1:0] c);
    if (expectSend) sendQ.push_back(c);
    @(negedge clk);
    fifoLevel = CNT_W'(lvl);
  endtask

  // Monitors: sample a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (fifoWrEn) begin
        if (fifoQ.size() == 0) check(1'b0, "R5 unexpected fifo write", int'(fifoWrData), 0);
        else begin
          logic [DATA_W-1:0] e;
          e = fifoQ.pop_front();
          check(fifoWrData == e, "R5 fifo data", int'(fifoWrData), int'(e));
        end
      end
      if (sendReq && autoAck && !sendAck) begin
        if (sendQ.size() == 0) check(1'b0, "R8 unexpected send request", int'(sendChar), 0);
        else begin
          logic [DATA_W-1:0] e;
          e = sendQ.pop_front();
          check(sendChar == e, "R6/R7 send char", int'(sendChar), int'(e));
        end
        sendAck = 1'b1;
      end else begin
        sendAck = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    check(txPause == 1'b0, "R1 txPause after reset", int'(txPause), 0);
    check(sendReq == 1'b0, "R1 sendReq after reset", int'(sendReq), 0);

    // Disabled: codes forwarded, no requests
    sendRx(8'h13, 1'b1);
    setLevel(500, 1'b0, '0);
    waitCycles(3);
    check(sendReq == 1'b0, "R10 no request while disabled", int'(sendReq), 0);
    check(txPause == 1'b0, "R10 no pause while disabled", int'(txPause), 0);

    // Enable with level already high: stop code with reset value
    autoAck = 1'b0;
    sendQ.push_back(8'h13);
    cfgWrite(2'd0, 1);
    waitCycles(2);
    check(sendReq == 1'b1, "R6 request on high level", int'(sendReq), 1);
    check(sendChar == 8'h13, "R1 default stop code", int'(sendChar), 8'h13);
    txDataReq = 1'b1; #1;
    check(txDataGrant == 1'b0, "R9 pending send blocks data", int'(txDataGrant), 0);
    txDataReq = 1'b0;
    autoAck = 1'b1;
    waitCycles(6);
    check(sendReq == 1'b0, "R8 no repeat while level stays high", int'(sendReq), 0);
    check(sendQ.size() == 0, "R6 stop code sent", sendQ.size(), 0);

    // Default threshold boundary 449/450
    setLevel(449, 1'b1, 8'h11);
    waitCycles(5);
    check(sendQ.size() == 0, "R7 go code on falling below", sendQ.size(), 0);
    setLevel(450, 1'b1, 8'h13);
    waitCycles(5);
    check(sendQ.size() == 0, "R1 threshold 450 reached", sendQ.size(), 0);
    setLevel(449, 1'b1, 8'h11);
    waitCycles(5);
    check(sendQ.size() == 0, "R7 go code again", sendQ.size(), 0);

    // Pause with idle transmitter
    sendRx(8'h13, 1'b0);
    #1;
    check(txPause == 1'b1, "R2 pause after stop code", int'(txPause), 1);
    txDataReq = 1'b1; #1;
    check(txDataGrant == 1'b0, "R9 pause blocks data", int'(txDataGrant), 0);
    txDataReq = 1'b0;
    sendRx(8'h11, 1'b0);
    #1;
    check(txPause == 1'b0, "R4 resume on go code", int'(txPause), 0);
    txDataReq = 1'b1; #1;
    check(txDataGrant == 1'b1, "R9 grant when free", int'(txDataGrant), 1);
    txDataReq = 1'b0;
    sendRx(8'h41, 1'b1);
    waitCycles(1);
    check(fifoQ.size() == 0, "R5 data and codes sorted", fifoQ.size(), 0);

    // Stop while a character is in flight
    @(negedge clk); txBusy = 1'b1;
    sendRx(8'h13, 1'b0);
    waitCycles(3);
    check(txPause == 1'b0, "R3 no pause while busy", int'(txPause), 0);
    txBusy = 1'b0;
    #(PERIOD/4);
    check(txPause == 1'b0, "R3 still low before edge", int'(txPause), 0);
    @(negedge clk); #(PERIOD/4);
    check(txPause == 1'b1, "R3 pause after busy ends", int'(txPause), 1);
    sendRx(8'h11, 1'b0);

    // Stop then go inside one busy phase
    @(negedge clk); txBusy = 1'b1;
    sendRx(8'h13, 1'b0);
    sendRx(8'h11, 1'b0);
    txBusy = 1'b0;
    waitCycles(3);
    check(txPause == 1'b0, "R4 go cancels armed stop", int'(txPause), 0);

    // New codes and threshold
    cfgWrite(2'd1, 8'h5A);
    cfgWrite(2'd2, 8'hA5);
    sendQ.push_back(8'hA5);
    cfgWrite(2'd3, 16);
    waitCycles(5);
    check(sendQ.size() == 0, "R11 new threshold and stop code", sendQ.size(), 0);
    setLevel(15, 1'b1, 8'h5A);
    waitCycles(5);
    check(sendQ.size() == 0, "R11 new go code", sendQ.size(), 0);
    sendRx(8'h13, 1'b1);
    sendRx(8'hA5, 1'b0);
    #1;
    check(txPause == 1'b1, "R11 new stop code pauses", int'(txPause), 1);

    // Requests while paused
    setLevel(16, 1'b1, 8'hA5);
    waitCycles(5);
    check(sendQ.size() == 0, "R9 stop sent while paused", sendQ.size(), 0);
    setLevel(15, 1'b1, 8'h5A);
    waitCycles(5);
    check(sendQ.size() == 0, "R9 go sent while paused", sendQ.size(), 0);

    // Disable with pause and pending request
    autoAck = 1'b0;
    setLevel(16, 1'b0, '0);
    waitCycles(2);
    check(sendReq == 1'b1 && txPause == 1'b1, "R9 request raised while paused",
          int'({sendReq, txPause}), 3);
    cfgWrite(2'd0, 0);
    waitCycles(1);
    check(txPause == 1'b0, "R10 pause cleared", int'(txPause), 0);
    check(sendReq == 1'b0, "R10 request dropped", int'(sendReq), 0);
    autoAck = 1'b1;
    sendRx(8'hA5, 1'b1);
    waitCycles(3);
    check(sendReq == 1'b0, "R10 still idle", int'(sendReq), 0);
    check(fifoQ.size() == 0, "R10 codes forwarded when disabled", fifoQ.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule